// File: doc/BRIEF.md
# Butterfly Multiply Round-Shift Lane

This block is one datapath lane of an integer transform engine. It evaluates a butterfly step of a DCT or FFT. Each valid beat carries two signed operands `op_a` and `op_b`, a signed coefficient `coef` and an unsigned shift count `shamt`.

The lane forms the sum and the difference of the operands one bit wider than the lane, so that neither can wrap. It multiplies each of them by the coefficient. It then rounds each product at the shift position and arithmetically shifts it right. Of each shifted product it keeps only the low `XLEN` bits.

The two results appear one clock after the beat that produced them and are held until the next valid beat. The lane width `XLEN` is a parameter, and the lane is meant to be built at 8, 16, 32 or 64 bits. Several lanes can be placed side by side by the surrounding logic.

Top module: `bfly_rshift_lane`

## Requirements
- R1: The sum and the difference of the operands are formed on `XLEN+1` bits after sign extension, so they never wrap. With `op_a = op_b` = the largest positive value, `coef = 1` and `shamt = 1`, the sum output equals that largest positive value.
- R2: `res_sum` carries the result derived from (op_a + op_b) * coef. `res_dif` carries the result derived from (op_a - op_b) * coef. All values are two's complement and the multiply is fully signed.
- R3: When `shamt` is 0, each result is the low `XLEN` bits of its product, with no rounding term added.
- R4: When `shamt` = n > 0, 2^(n-1) is added to the product before shifting, so ties round toward positive infinity. For example, at n = 1 a product of 3 gives 2 and a product of -3 gives -1.
- R5: After rounding, the product is shifted right arithmetically by n. The result is the low `XLEN` bits of the shifted value, which is floor(p / 2^n + 1/2) mod 2^XLEN.
- R6: `out_vld` is `in_vld` delayed by exactly one clock. The results of a valid beat appear on the outputs in the same cycle that `out_vld` rises.
- R7: In a cycle with `in_vld` low, `res_sum` and `res_dif` keep their previous values whatever the other inputs do.
- R8: While `rst_n` is low at a clock edge, `out_vld`, `res_sum` and `res_dif` are cleared to 0.
- R9: The lane gives the results of R2 to R5 when built with `XLEN` of 8, 16, 32 and 64.
- R10: `shamt` is a 5-bit unsigned count. Legal values are 0 to XLEN-1 for 8- and 16-bit lanes, and 0 to 31 for 32- and 64-bit lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input beat valid |
| op_a | input | XLEN | First signed operand |
| op_b | input | XLEN | Second signed operand |
| coef | input | XLEN | Signed coefficient |
| shamt | input | 5 | Unsigned rounding shift count |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| res_sum | output | XLEN | Rounded, shifted (a+b)*c |
| res_dif | output | XLEN | Rounded, shifted (a-b)*c |

## Verification
Four lanes of width 16, 8, 32 and 64 are driven with the same stimulus. Each result is compared with a reference that uses wide integer division and a floor correction.

Random operands exercise both signs and full-range coefficients at every legal shift count. These cases separate a correct signed multiply from an unsigned one, and a correct arithmetic shift from a logical one.

Directed beats cover three further points:
- Saturating operands show whether the pre-add was widened.
- Products of +3 and -3 at a shift of 1 show whether ties round upward rather than away from zero.
- A zero shift shows that no stray rounding bit is added.

Idle cycles with changing inputs show that the outputs hold.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int SHAMT_W = 5;
  localparam int NUM_BR  = 2;
  localparam int BR_SUM  = 0;
  localparam int BR_DIF  = 1;
endpackage

// File: rtl/bfly_presum.sv
module bfly_presum #(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic [XLEN:0]   sum_o,
  output logic [XLEN:0]   dif_o
);
  localparam int EW = XLEN + 1;

  function automatic logic [EW-1:0] widen(input logic [XLEN-1:0] v);
    return {v[XLEN-1], v};
  endfunction

  always_comb begin
    sum_o = widen(op_a) + widen(op_b);
    dif_o = widen(op_a) - widen(op_b);
  end
endmodule

// File: rtl/bfly_smul.sv
module bfly_smul #(
  parameter int AW = 17,
  parameter int BW = 16
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [AW+BW-1:0] p_o
);
  localparam int PW = AW + BW;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  always_comb begin
    a_ext = PW'($signed(a_i));
    b_ext = PW'($signed(b_i));
    p_o   = a_ext * b_ext;
  end
endmodule

// File: rtl/bfly_rndshift.sv
module bfly_rndshift #(
  parameter int PW   = 33,
  parameter int XLEN = 16,
  parameter int SHW  = 5
) (
  input  logic [PW-1:0]   prod_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic [XLEN-1:0] res_o
);
  localparam int RW = PW + 1;

  logic signed [RW-1:0] ext;
  logic signed [RW-1:0] half;
  logic signed [RW-1:0] tot;

  always_comb begin
    ext = RW'($signed(prod_i));
    if (shamt_i == '0) half = '0;
    else               half = RW'(1) << (shamt_i - SHW'(1));
    tot   = ext + half;
    res_o = XLEN'(tot >>> shamt_i);
  end
endmodule

// File: rtl/bfly_rshift_lane.sv
module bfly_rshift_lane #(
  parameter int XLEN = 16,
  parameter int SHW  = bfly_pkg::SHAMT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] coef,
  input  logic [SHW-1:0]  shamt,
  output logic            out_vld,
  output logic [XLEN-1:0] res_sum,
  output logic [XLEN-1:0] res_dif
);
  localparam int SUMW = XLEN + 1;
  localparam int PW   = SUMW + XLEN;

  logic [SUMW-1:0] sum_w;
  logic [SUMW-1:0] dif_w;
  logic [SUMW-1:0] opnd [bfly_pkg::NUM_BR];
  logic [PW-1:0]   prod [bfly_pkg::NUM_BR];
  logic [XLEN-1:0] rnd  [bfly_pkg::NUM_BR];
  logic [PW-1:0]   prod_sum;
  logic [PW-1:0]   prod_dif;

  bfly_presum #(.XLEN(XLEN)) u_pre (
    .op_a (op_a),
    .op_b (op_b),
    .sum_o(sum_w),
    .dif_o(dif_w)
  );

  for (genvar br = 0; br < bfly_pkg::NUM_BR; br++) begin : g_br
    if (br == bfly_pkg::BR_SUM) begin : g_src
      assign opnd[br] = sum_w;
    end else begin : g_src
      assign opnd[br] = dif_w;
    end

    bfly_smul #(.AW(SUMW), .BW(XLEN)) u_mul (
      .a_i(opnd[br]),
      .b_i(coef),
      .p_o(prod[br])
    );

    bfly_rndshift #(.PW(PW), .XLEN(XLEN), .SHW(SHW)) u_rnd (
      .prod_i (prod[br]),
      .shamt_i(shamt),
      .res_o  (rnd[br])
    );
  end

  assign prod_sum = prod[bfly_pkg::BR_SUM];
  assign prod_dif = prod[bfly_pkg::BR_DIF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      res_sum <= '0;
      res_dif <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        res_sum <= rnd[bfly_pkg::BR_SUM];
        res_dif <= rnd[bfly_pkg::BR_DIF];
      end
    end
  end
endmodule

// File: rtl/bfly_rshift_chk.sv
module bfly_rshift_chk #(
  parameter int XLEN = 16,
  parameter int SHW  = 5,
  parameter int PW   = 2 * XLEN + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [SHW-1:0]  shamt,
  input logic            out_vld,
  input logic [XLEN-1:0] res_sum,
  input logic [XLEN-1:0] res_dif,
  input logic [XLEN:0]   sum_w,
  input logic [XLEN:0]   dif_w,
  input logic [PW-1:0]   prod_sum,
  input logic [PW-1:0]   prod_dif
);
  localparam int CW = XLEN + 2;

  logic signed [CW-1:0] s_x, d_x, a_x, b_x;
  assign s_x = CW'($signed(sum_w));
  assign d_x = CW'($signed(dif_w));
  assign a_x = CW'($signed(op_a));
  assign b_x = CW'($signed(op_b));

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!out_vld && res_sum == '0 && res_dif == '0)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ((s_x + d_x) == (a_x <<< 1) && (s_x - d_x) == (b_x <<< 1))); // R1

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld); // R6

  AST_VLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(res_sum) && $stable(res_dif))); // R7

  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && shamt == '0) |=>
      (res_sum == $past(prod_sum[XLEN-1:0]) && res_dif == $past(prod_dif[XLEN-1:0]))); // R3

  AST_ZERO_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && prod_sum == '0) |=> (res_sum == '0)); // R5
endmodule

bind bfly_rshift_lane bfly_rshift_chk #(.XLEN(XLEN), .SHW(SHW), .PW(PW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .op_a    (op_a),
  .op_b    (op_b),
  .shamt   (shamt),
  .out_vld (out_vld),
  .res_sum (res_sum),
  .res_dif (res_dif),
  .sum_w   (sum_w),
  .dif_w   (dif_w),
  .prod_sum(prod_sum),
  .prod_dif(prod_dif)
);

// File: tb/sim_bfly_rshift_lane.sv
`timescale 1ns/1ps
module sim_bfly_rshift_lane;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [63:0] a64 = '0, b64 = '0, c64 = '0;
  logic [4:0]  n5 = '0;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  localparam int WD [4] = '{16, 8, 32, 64};

  logic        vld [4];
  logic [63:0] got_sum [4];
  logic [63:0] got_dif [4];

  logic [15:0] s0, d0;
  logic [7:0]  s1, d1;
  logic [31:0] s2, d2;
  logic [63:0] s3, d3;

  bfly_rshift_lane #(.XLEN(16)) u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .op_a(a64[15:0]), .op_b(b64[15:0]), .coef(c64[15:0]), .shamt({1'b0, n5[3:0]}),
    .out_vld(vld[0]), .res_sum(s0), .res_dif(d0));
  bfly_rshift_lane #(.XLEN(8)) u1 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .op_a(a64[7:0]), .op_b(b64[7:0]), .coef(c64[7:0]), .shamt({2'b0, n5[2:0]}),
    .out_vld(vld[1]), .res_sum(s1), .res_dif(d1));
  bfly_rshift_lane #(.XLEN(32)) u2 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .op_a(a64[31:0]), .op_b(b64[31:0]), .coef(c64[31:0]), .shamt(n5),
    .out_vld(vld[2]), .res_sum(s2), .res_dif(d2));
  bfly_rshift_lane #(.XLEN(64)) u3 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .op_a(a64), .op_b(b64), .coef(c64), .shamt(n5),
    .out_vld(vld[3]), .res_sum(s3), .res_dif(d3));

  assign got_sum[0] = {48'b0, s0};
  assign got_dif[0] = {48'b0, d0};
  assign got_sum[1] = {56'b0, s1};
  assign got_dif[1] = {56'b0, d1};
  assign got_sum[2] = {32'b0, s2};
  assign got_dif[2] = {32'b0, d2};
  assign got_sum[3] = s3;
  assign got_dif[3] = d3;

  function automatic logic signed [159:0] sx(input logic [63:0] v, input int w);
    logic [159:0] t;
    t = {96'b0, v} << (160 - w);
    return $signed(t) >>> (160 - w);
  endfunction

  // floor(p / 2^n + 1/2) by division with a floor correction, truncated to w bits
  function automatic logic [63:0] ref_lane(input int w, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] c, input int n, input bit dif);
    logic signed [159:0] p, t, d, q;
    logic [63:0] mask;
    p = (dif ? (sx(a, w) - sx(b, w)) : (sx(a, w) + sx(b, w))) * sx(c, w);
    t = (n > 0) ? p + (160'sd1 <<< (n - 1)) : p;
    d = 160'sd1 <<< n;
    q = t / d;
    if ((t % d) != 0 && t < 0) q = q - 1;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    return q[63:0] & mask;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act,
      input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic beat(input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] c, input logic [4:0] n);
    @(negedge clk);
    a64 = a; b64 = b; c64 = c; n5 = n; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      int w = WD[k];
      int n = int'(n5) % ((w < 32) ? w : 32);
      chk(req, $sformatf("w%0d sum", w), got_sum[k], ref_lane(w, a64, b64, c64, n, 1'b0));
      chk(req, $sformatf("w%0d dif", w), got_dif[k], ref_lane(w, a64, b64, c64, n, 1'b1));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] hs, hd;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int k = 0; k < 4; k++) begin
      chk("R8", "vld", {63'b0, vld[k]}, 64'd0);
      chk("R8", "sum", got_sum[k], 64'd0);
    end
    rst_n = 1'b1;

    // R1: widened pre-add, saturating operands
    beat(64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, 64'd1, 5'd1);
    chk("R1", "w16 sum", got_sum[0], 64'h7FFF);
    check_all("R1");

    // R4: ties round toward +inf (3 -> 2, -3 -> -1)
    beat(64'd0, 64'd3, 64'd1, 5'd1);
    chk("R4", "w16 sum", got_sum[0], 64'h0002);
    chk("R4", "w16 dif", got_dif[0], 64'hFFFF);
    check_all("R4");

    // R6: valid timing
    chk("R6", "vld high", {63'b0, vld[0]}, 64'd1);

    // R3: zero shift, no rounding
    beat(64'h0000_0000_1234_9234, 64'h0000_0000_0F0F_8F0F, 64'h0000_0000_5A5A_DA5A, 5'd0);
    check_all("R3");
    @(negedge clk);
    chk("R6", "vld low", {63'b0, vld[0]}, 64'd0);

    // R7: inputs change while idle, outputs hold
    hs = got_sum[0]; hd = got_dif[0];
    a64 = 64'h5555; b64 = 64'h1111; c64 = 64'h7777; n5 = 5'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R7", "sum hold", got_sum[0], hs);
    chk("R7", "dif hold", got_dif[0], hd);

    // R5: large shift and truncation of negative products
    beat(64'h8000_0000_8000_8080, 64'h7FFF_FFFF_7FFF_7F7F, 64'h7FFF_FFFF_7FFF_7F7F, 5'd20);
    check_all("R5");
    beat(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31);
    check_all("R10");

    // R2 / R9 / R10: random beats at every width and legal shift
    for (int i = 0; i < 300; i++) begin
      beat({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom % 32));
      check_all("R2_R9_R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule